// File: doc/BRIEF.md
# Multicore Boot Release Spin Table

This block is a small memory-mapped register file through which a boot processor starts secondary cores. It holds one 32-byte record per core slot, 32 slots in all, for a 1 KiB window. Each record carries a 64-bit start address, a 64-bit boot argument and a 32-bit processor identifier, plus reserved space. At reset every start address holds the value 1. Bit 0 of the start address is the "still spinning" flag.

The boot processor writes a record through a synchronous bus port. The port is word addressed and takes byte enables, and all fields are big-endian. The block checks each accepted write. If the write leaves bit 0 of that record's start address clear, the block sends that core a one-cycle, one-hot release pulse. Beside the pulse it presents four values: the entry offset inside a 64 MiB mapping window, the window base, the boot argument and the window size. In the same cycle it rewrites the record's identifier field with the core's hardware identifier and presents that identifier too. Slot 0 belongs to the primary core, which never spins, so writes to it are dropped. Writes to slots with no core present are dropped as well.

Top module: `spin_release_table`

## Requirements
- R1: After reset, record n reads back as follows: start address 1, argument n, identifier field n, and zero in both reserved fields.
- R2: A read with a legal enable pattern returns the addressed word on rdData one cycle later. Disabled lanes read as zero. The byte at the lowest address of the word travels on data bits 31:24 with enable bit 3, and the byte at the highest address travels on bits 7:0 with enable bit 0.
- R3: The legal enable patterns are 0001, 0010, 0100, 1000, 0011, 1100 and 1111. A read with any other pattern sets rdErr for one cycle, one cycle later, with rdData zero.
- R4: An accepted write updates only the enabled bytes of the addressed word. It uses the same lane mapping as R2.
- R5: A write changes nothing and releases nothing in three cases: it targets record 0, it targets a record whose index is NUM_CORES or more, or it uses an illegal enable pattern.
- R6: An accepted write that leaves bit 0 of the record's start address at 0 raises releasePulse[n] for exactly one cycle, the cycle after the write. Other pulse bits stay low. No pulse follows when that bit is 1.
- R7: With the pulse, relEntry equals the start address modulo 2^26. relBase equals the start address with its low 26 bits cleared.
- R8: With the pulse, relArg equals the record's argument after the write. relWinSize always reads 2^26.
- R9: On a release, the record's identifier field becomes coreHwId of that core, and relCoreId presents the same value.
- R10: Every further accepted write to a record whose spin bit is already 0 releases that core again. This includes a write to the argument alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wordAddr | input | 8 | Word address: record index in the top 5 bits, word within the record in the low 3 bits |
| byteEn | input | 4 | Byte enables, bit 3 for the lowest-addressed byte |
| wrData | input | 32 | Write data, big-endian lanes |
| rdData | output | 32 | Read data, valid the cycle after rdEn |
| rdErr | output | 1 | Illegal read pattern flag |
| coreHwId | input | NUM_CORES*32 | Hardware identifier of each core, core c at bits c*32 upward |
| releasePulse | output | NUM_CORES | One-hot, one-cycle release per core |
| relEntry | output | 64 | Entry offset inside the window |
| relBase | output | 64 | Window base address |
| relArg | output | 64 | Boot argument |
| relWinSize | output | 64 | Window size, 64 MiB |
| relCoreId | output | 32 | Released core's identifier |

## Verification
The assertions assume that rdEn and wrEn are never high in the same cycle. They also assume that the identifier inputs hold steady across the cycle in which a write lands. The bench issues one operation per cycle and sets the identifiers once, before reset ends, so both assumptions hold. Random writes cover three kinds of target: the primary slot, absent slots, and the present slots. They mix legal and illegal enable patterns. On writes to the start address word they pick the spin bit at random, so releases, repeated releases and ignored writes all occur.

// File: rtl/spin_pkg.sv
package spin_pkg;
  localparam int REC_BYTES = 32;
  localparam int START_OFF = 0;
  localparam int ARG_OFF   = 8;
  localparam int ID_OFF    = 20;

  typedef struct packed {
    logic wrAccept;
    logic relGo;
    logic rdFire;
    logic rdLegal;
  } ctlStrobes_t;

  function automatic logic legalPattern(input logic [3:0] be);
    return be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111};
  endfunction

  function automatic logic [7:0] resetByte(input int rec, input int off);
    logic [63:0] startVal;
    logic [63:0] argVal;
    logic [31:0] idVal;
    startVal = 64'd1;
    argVal   = 64'(rec);
    idVal    = 32'(rec);
    if (off >= START_OFF && off < START_OFF + 8) return startVal[63 - 8*(off - START_OFF) -: 8];
    if (off >= ARG_OFF && off < ARG_OFF + 8)     return argVal[63 - 8*(off - ARG_OFF) -: 8];
    if (off >= ID_OFF && off < ID_OFF + 4)       return idVal[31 - 8*(off - ID_OFF) -: 8];
    return 8'h00;
  endfunction
endpackage

// File: rtl/spin_ctrl.sv
module spin_ctrl
  import spin_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [3:0]        byteEn,
  input  logic [IDX_W-1:0]  recIdx,
  input  logic              spinBitNew,
  output ctlStrobes_t       ctl,
  output logic              rdErr
);
  logic patOk;
  logic corePresent;

  always_comb begin
    patOk       = legalPattern(byteEn);
    corePresent = (recIdx != '0) && (int'(recIdx) < NUM_CORES);
    ctl.wrAccept = wrEn && patOk && corePresent;
    ctl.relGo    = ctl.wrAccept && !spinBitNew;
    ctl.rdFire   = rdEn;
    ctl.rdLegal  = patOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdErr <= 1'b0;
    else       rdErr <= rdEn && !patOk;
  end
endmodule

// File: rtl/spin_data.sv
module spin_data
  import spin_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int NUM_RECORDS = 32,
  parameter int ID_W        = 32,
  parameter int WIN_LOG2    = 26,
  parameter int WA_W        = 8,
  parameter int IDX_W       = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [WA_W-1:0]           wordAddr,
  input  logic [3:0]                byteEn,
  input  logic [31:0]               wrData,
  input  logic [NUM_CORES*ID_W-1:0] coreHwId,
  input  ctlStrobes_t               ctl,
  output logic                      spinBitNew,
  output logic [31:0]               rdData,
  output logic [NUM_CORES-1:0]      releasePulse,
  output logic [63:0]               relEntry,
  output logic [63:0]               relBase,
  output logic [63:0]               relArg,
  output logic [ID_W-1:0]           relCoreId
);
  localparam int OFF_W    = $clog2(REC_BYTES);
  localparam int WSEL_W   = OFF_W - 2;
  localparam int MEM_SIZE = NUM_RECORDS * REC_BYTES;
  localparam logic [63:0] WIN_MASK = (64'd1 << WIN_LOG2) - 64'd1;

  logic [7:0] mem [MEM_SIZE];
  logic [7:0] recNew [REC_BYTES];
  logic [IDX_W-1:0]  recIdx;
  logic [WSEL_W-1:0] wordSel;
  logic [63:0] startNew, argNew;
  logic [ID_W-1:0] hwSel;
  logic [31:0] rdWord;

  assign recIdx  = wordAddr[WA_W-1 -: IDX_W];
  assign wordSel = wordAddr[WSEL_W-1:0];

  always_comb begin
    for (int o = 0; o < REC_BYTES; o++) begin
      recNew[o] = mem[{recIdx, OFF_W'(o)}];
      if ((o / 4) == int'(wordSel) && byteEn[3 - (o % 4)])
        recNew[o] = wrData[31 - 8*(o % 4) -: 8];
    end
    for (int k = 0; k < 8; k++) begin
      startNew[63 - 8*k -: 8] = recNew[START_OFF + k];
      argNew[63 - 8*k -: 8]   = recNew[ARG_OFF + k];
    end
    spinBitNew = startNew[0];
    hwSel = '0;
    for (int c = 0; c < NUM_CORES; c++)
      if (int'(recIdx) == c) hwSel = coreHwId[c*ID_W +: ID_W];
    for (int k = 0; k < 4; k++)
      rdWord[31 - 8*k -: 8] = byteEn[3-k] ? mem[{wordAddr, 2'(k)}] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_RECORDS; r++)
        for (int o = 0; o < REC_BYTES; o++)
          mem[r*REC_BYTES + o] <= resetByte(r, o);
    end else if (ctl.wrAccept) begin
      for (int o = 0; o < REC_BYTES; o++)
        mem[{recIdx, OFF_W'(o)}] <= recNew[o];
      if (ctl.relGo)
        for (int k = 0; k < ID_W/8; k++)
          mem[{recIdx, OFF_W'(ID_OFF + k)}] <= hwSel[ID_W-1 - 8*k -: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      releasePulse <= '0;
      relEntry     <= '0;
      relBase      <= '0;
      relArg       <= '0;
      relCoreId    <= '0;
      rdData       <= '0;
    end else begin
      for (int c = 0; c < NUM_CORES; c++)
        releasePulse[c] <= ctl.relGo && (int'(recIdx) == c);
      if (ctl.relGo) begin
        relEntry  <= startNew & WIN_MASK;
        relBase   <= startNew & ~WIN_MASK;
        relArg    <= argNew;
        relCoreId <= hwSel;
      end
      if (ctl.rdFire) rdData <= ctl.rdLegal ? rdWord : 32'h0;
    end
  end
endmodule

// File: rtl/spin_release_table.sv
module spin_release_table
  import spin_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int NUM_RECORDS = 32,
  parameter int ID_W        = 32,
  parameter int WIN_LOG2    = 26
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic                      rdEn,
  input  logic [$clog2(NUM_RECORDS*REC_BYTES/4)-1:0] wordAddr,
  input  logic [3:0]                byteEn,
  input  logic [31:0]               wrData,
  output logic [31:0]               rdData,
  output logic                      rdErr,
  input  logic [NUM_CORES*ID_W-1:0] coreHwId,
  output logic [NUM_CORES-1:0]      releasePulse,
  output logic [63:0]               relEntry,
  output logic [63:0]               relBase,
  output logic [63:0]               relArg,
  output logic [63:0]               relWinSize,
  output logic [ID_W-1:0]           relCoreId
);
  localparam int WA_W  = $clog2(NUM_RECORDS*REC_BYTES/4);
  localparam int IDX_W = $clog2(NUM_RECORDS);

  ctlStrobes_t ctl;
  logic spinBitNew;

  assign relWinSize = 64'd1 << WIN_LOG2;

  spin_ctrl #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .byteEn(byteEn),
    .recIdx(wordAddr[WA_W-1 -: IDX_W]), .spinBitNew(spinBitNew),
    .ctl(ctl), .rdErr(rdErr)
  );

  spin_data #(
    .NUM_CORES(NUM_CORES), .NUM_RECORDS(NUM_RECORDS), .ID_W(ID_W),
    .WIN_LOG2(WIN_LOG2), .WA_W(WA_W), .IDX_W(IDX_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .wordAddr(wordAddr), .byteEn(byteEn), .wrData(wrData),
    .coreHwId(coreHwId), .ctl(ctl), .spinBitNew(spinBitNew), .rdData(rdData),
    .releasePulse(releasePulse), .relEntry(relEntry), .relBase(relBase),
    .relArg(relArg), .relCoreId(relCoreId)
  );
endmodule

// File: rtl/spin_release_chk.sv
module spin_release_chk #(
  parameter int NUM_CORES = 4,
  parameter int ID_W      = 32,
  parameter int WA_W      = 8,
  parameter int IDX_W     = 5
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      wrEn,
  input logic                      rdEn,
  input logic [WA_W-1:0]           wordAddr,
  input logic [31:0]               rdData,
  input logic                      rdErr,
  input logic [NUM_CORES*ID_W-1:0] coreHwId,
  input logic [NUM_CORES-1:0]      releasePulse,
  input logic [ID_W-1:0]           relCoreId
);
  p_onehot_r6: assert property (@(posedge clk) disable iff (!rstN) $onehot0(releasePulse));

  p_no_primary_r5: assert property (@(posedge clk) disable iff (!rstN) !releasePulse[0]);

  p_err_follows_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> ($past(rdEn) && rdData == 32'h0));

  for (genvar c = 1; c < NUM_CORES; c++) begin : g_core
    p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
      releasePulse[c] |-> ($past(wrEn) && int'($past(wordAddr[WA_W-1 -: IDX_W])) == c));
    p_id_presented_r9: assert property (@(posedge clk) disable iff (!rstN)
      releasePulse[c] |-> relCoreId == $past(coreHwId[c*ID_W +: ID_W]));
  end
endmodule

bind spin_release_table spin_release_chk #(
  .NUM_CORES(NUM_CORES), .ID_W(ID_W), .WA_W(WA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wordAddr(wordAddr),
  .rdData(rdData), .rdErr(rdErr), .coreHwId(coreHwId),
  .releasePulse(releasePulse), .relCoreId(relCoreId)
);

// File: tb/tb_spin_release_table.sv
module tb_spin_release_table;
  localparam int NC = 4;
  localparam int NR = 32;
  localparam int WL = 26;
  localparam logic [63:0] MASK = (64'd1 << WL) - 64'd1;

  logic clk = 0;
  logic rstN = 0;
  logic wrEn = 0, rdEn = 0;
  logic [7:0] wordAddr = '0;
  logic [3:0] byteEn = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic rdErr;
  logic [NC*32-1:0] coreHwId;
  logic [NC-1:0] releasePulse;
  logic [63:0] relEntry, relBase, relArg, relWinSize;
  logic [31:0] relCoreId;

  logic [7:0] mdl [NR*32];
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spin_release_table #(.NUM_CORES(NC)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wordAddr(wordAddr),
    .byteEn(byteEn), .wrData(wrData), .rdData(rdData), .rdErr(rdErr),
    .coreHwId(coreHwId), .releasePulse(releasePulse), .relEntry(relEntry),
    .relBase(relBase), .relArg(relArg), .relWinSize(relWinSize), .relCoreId(relCoreId)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit legal(input logic [3:0] be);
    return be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111};
  endfunction

  function automatic logic [63:0] field64(input int rec, input int off);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[63-8*k -: 8] = mdl[rec*32 + off + k];
    return v;
  endfunction

  task automatic doRead(input int rec, input int word, input logic [3:0] be, input string req);
    logic [31:0] exp;
    exp = '0;
    if (legal(be))
      for (int k = 0; k < 4; k++) if (be[3-k]) exp[31-8*k -: 8] = mdl[rec*32 + word*4 + k];
    wordAddr = 8'(rec*8 + word); byteEn = be; rdEn = 1;
    @(negedge clk);
    rdEn = 0;
    chk(rdData === exp, req, 64'(rdData), 64'(exp));
    chk(rdErr === !legal(be), req, 64'(rdErr), 64'(!legal(be)));
  endtask

  task automatic doWrite(input int rec, input int word, input logic [3:0] be, input logic [31:0] d, input string req);
    bit acc;
    logic [63:0] st, arg;
    logic [NC-1:0] expP;
    logic [31:0] hid;
    acc = legal(be) && rec != 0 && rec < NC;
    expP = '0; hid = '0;
    if (acc) begin
      for (int k = 0; k < 4; k++) if (be[3-k]) mdl[rec*32 + word*4 + k] = d[31-8*k -: 8];
      st = field64(rec, 0);
      arg = field64(rec, 8);
      if (!st[0]) begin
        expP = NC'(1) << rec;
        hid = coreHwId[rec*32 +: 32];
        for (int k = 0; k < 4; k++) mdl[rec*32 + 20 + k] = hid[31-8*k -: 8];
      end
    end
    wordAddr = 8'(rec*8 + word); byteEn = be; wrData = d; wrEn = 1;
    @(negedge clk);
    wrEn = 0;
    chk(releasePulse === expP, req, 64'(releasePulse), 64'(expP));
    if (expP != '0) begin
      chk(relEntry === (st & MASK), "R7 entry", relEntry, st & MASK);
      chk(relBase === (st & ~MASK), "R7 base", relBase, st & ~MASK);
      chk(relArg === arg, "R8 arg", relArg, arg);
      chk(relWinSize === 64'h400_0000, "R8 window", relWinSize, 64'h400_0000);
      chk(relCoreId === hid, "R9 id out", 64'(relCoreId), 64'(hid));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [3:0] pats [8];
    void'($urandom(32'h5EED_1234));
    pats = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111, 4'b0110};
    for (int c = 0; c < NC; c++) coreHwId[c*32 +: 32] = $urandom;
    for (int r = 0; r < NR; r++)
      for (int o = 0; o < 32; o++) begin
        mdl[r*32+o] = 8'h00;
        if (o == 7) mdl[r*32+o] = 8'h01;
        if (o == 15 || o == 23) mdl[r*32+o] = 8'(r);
      end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset contents
    chk(releasePulse === '0, "R1 no pulse", 64'(releasePulse), 0);
    chk(relWinSize === 64'h400_0000, "R8 window", relWinSize, 64'h400_0000);
    for (int r = 0; r < NR; r += 7)
      for (int w = 0; w < 8; w++) doRead(r, w, 4'b1111, "R1 reset read");

    // R2 lanes and R3 illegal reads
    doRead(2, 5, 4'b0001, "R2 low lane");
    doRead(2, 5, 4'b1000, "R2 high lane");
    doRead(3, 3, 4'b1100, "R2 half");
    doRead(1, 2, 4'b0110, "R3 illegal read");
    doRead(1, 2, 4'b0000, "R3 empty read");

    // R4 partial write, R5 discards
    doWrite(2, 2, 4'b0010, 32'hAABBCCDD, "R4 byte write");
    doRead(2, 2, 4'b1111, "R4 readback");
    doWrite(0, 1, 4'b1111, 32'h0, "R5 primary");
    doRead(0, 1, 4'b1111, "R5 primary unchanged");
    doWrite(5, 1, 4'b1111, 32'h0, "R5 absent core");
    doRead(5, 1, 4'b1111, "R5 absent unchanged");
    doWrite(3, 1, 4'b1010, 32'h0, "R5 illegal write");
    doRead(3, 1, 4'b1111, "R5 illegal unchanged");

    // R6-R9 directed release
    doWrite(3, 0, 4'b1111, 32'h0000_0001, "R6 still spinning");
    doWrite(3, 2, 4'b1111, 32'h1357_9BDF, "R8 arg set");
    doWrite(3, 1, 4'b1111, 32'h2345_6788, "R6 release");
    @(negedge clk);
    chk(releasePulse === '0, "R6 one cycle", 64'(releasePulse), 0);
    doRead(3, 5, 4'b1111, "R9 id rewritten");
    doWrite(3, 3, 4'b0001, 32'h0000_0042, "R10 re-release");
    doWrite(3, 1, 4'b0001, 32'h0000_0001, "R6 spin again");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int rec, word;
      logic [3:0] be;
      logic [31:0] d;
      rec = $urandom % 6;
      word = $urandom % 8;
      be = pats[$urandom % 8];
      d = $urandom;
      if ($urandom % 3 == 0) doRead(rec, word, be, "R2 random read");
      else doWrite(rec, word, be, d, "R6 random write");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule